// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter that sits behind an 8-way input multiplexer. A one-cycle start request, taken while the block is idle, captures a channel number and a clock-select bit. The block then derives a conversion clock from the system clock, dividing by 4 or by 8, and holds the sample-and-hold in its acquire phase for the first 10 conversion-clock periods. During the next 8 periods it drives trial codes to an external DAC, most significant bit first. It keeps or drops each trial bit according to a single comparator input.

The comparator, DAC and sample-and-hold are outside the block. Once the trial bits are settled, the remaining periods pass without activity, so that every conversion lasts exactly 31 conversion-clock periods. The finished code then appears on the result port with a one-cycle done pulse. An interrupt line is raised at the same time and stays high until the next conversion is accepted.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy, done, irq, sample_en and result are all zero, chan_mux is 0 and dac_code is 00h.
- R2: A start sampled high while busy is low is accepted at that clock edge. From the next cycle busy is high and chan_mux shows the chan_in value captured at that edge.
- R3: The conversion clock period is 4 system clocks when the clk_sel value captured at start is 0, and 8 when it is 1. busy stays high for exactly 31 conversion periods: 124 or 248 system clocks.
- R4: sample_en is high for the first 10 conversion periods of each conversion (40 or 80 system clocks) and is low otherwise. dac_code is 00h while sample_en is high.
- R5: In conversion periods 10 to 17, bit 7 down to bit 0 is tried in turn. dac_code equals the bits kept so far OR the current trial bit. A bit is kept when cmp_hi is 1 at the end of its period.
- R6: With a comparator reporting input >= dac_code, the result equals the input code over the full 00h to FFh range.
- R7: done is high for exactly one system clock, in the cycle in which result takes its new value. result does not change at any other time.
- R8: irq rises together with done and stays high until the next start is accepted; it is low from the cycle after acceptance.
- R9: A start that arrives while busy is ignored. The conversion length, the channel and the clock select of the running conversion are unchanged.
- R10: Changes to chan_in or clk_sel after acceptance do not affect chan_mux or the result of the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken only when idle |
| chan_in | input | 3 | Channel to convert, captured at start |
| clk_sel | input | 1 | Conversion clock select: 0 divides by 4, 1 divides by 8 |
| cmp_hi | input | 1 | Comparator: 1 when the held input is at or above dac_code |
| chan_mux | output | 3 | Channel select to the analog multiplexer |
| sample_en | output | 1 | Sample-and-hold acquire enable |
| dac_code | output | 8 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Last converted code |
| done | output | 1 | One-cycle pulse when result updates |
| irq | output | 1 | Conversion-complete interrupt, held until next start |

## Verification
On every cycle, the assertions check the following: the single-cycle done pulse and the stability of the result between pulses; the interrupt rising only with done and clearing on acceptance; acquire being confined to a busy conversion with a zero DAC code; at most one trial bit at a time; the channel held steady through a conversion; and every busy window lasting exactly 124 or 248 clocks.

The bench scenarios cover the following: that the code is correct for each input value; that the trials really run MSB first against the comparator; that acquire spans exactly 10 periods at both divide ratios; and that a start or channel change in mid-conversion leaves the captured channel and the outcome untouched.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_TRIAL,
    PH_SETTLE
  } phase_e;

  // Which phase a conversion-clock period index belongs to.
  function automatic phase_e classify(input int p, input int n_samp, input int n_bits);
    if (p < n_samp)
      return PH_SAMPLE;
    else if (p < n_samp + n_bits)
      return PH_TRIAL;
    else
      return PH_SETTLE;
  endfunction

  // Bit position under trial in period p (MSB is tried first).
  function automatic int trial_pos(input int p, input int n_samp, input int n_bits);
    return n_bits - 1 - (p - n_samp);
  endfunction

  // System clocks spent in a conversion.
  function automatic int conv_cycles(input int periods, input int div);
    return periods * div;
  endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int CW = $clog2(DIV_SLOW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_phase_ctr.sv
module sar_phase_ctr
  import sar_seq_pkg::*;
#(
  parameter int SAMPLE_PERIODS = 10,
  parameter int RES_W          = 8,
  parameter int TOTAL_PERIODS  = 31,
  parameter int IW             = $clog2(RES_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output phase_e        phase,
  output logic [IW-1:0] bitpos,
  output logic          last
);
  localparam int PW = $clog2(TOTAL_PERIODS + 1);

  logic [PW-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      period <= '0;
    else if (!run)
      period <= '0;
    else if (tick)
      period <= period + 1'b1;
  end

  assign phase  = run ? classify(int'(period), SAMPLE_PERIODS, RES_W) : PH_IDLE;
  assign bitpos = (phase == PH_TRIAL)
                  ? IW'(trial_pos(int'(period), SAMPLE_PERIODS, RES_W)) : '0;
  assign last   = run && tick && (period == PW'(TOTAL_PERIODS - 1));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 8,
  parameter int IW    = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             step,
  input  logic [IW-1:0]    bitpos,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] trial_mask,
  output logic [RES_W-1:0] code
);
  logic [RES_W-1:0] acc;

  assign trial_mask = active ? (RES_W'(1) << bitpos) : '0;
  assign code       = acc | trial_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (clear)
      acc <= '0;
    else if (step && active && cmp_hi)
      acc <= acc | trial_mask;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W          = 8,
  parameter int CH_W           = 3,
  parameter int SAMPLE_PERIODS = 10,
  parameter int TOTAL_PERIODS  = 31,
  parameter int DIV_FAST       = 4,
  parameter int DIV_SLOW       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_in,
  input  logic             clk_sel,
  input  logic             cmp_hi,
  output logic [CH_W-1:0]  chan_mux,
  output logic             sample_en,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             irq
);
  localparam int IW = $clog2(RES_W);

  // Named internal events, observed by the bound checker.
  logic             accept;
  logic             conv_tick;
  logic             end_of_conv;
  logic             sel_q;
  phase_e           phase;
  logic [IW-1:0]    bitpos;
  logic [RES_W-1:0] trial_mask;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sel_q    <= 1'b0;
      chan_mux <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      sel_q    <= clk_sel;
      chan_mux <= chan_in;
    end else if (end_of_conv) begin
      busy     <= 1'b0;
    end
  end

  sar_clk_div #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .slow  (sel_q),
    .tick  (conv_tick)
  );

  sar_phase_ctr #(
    .SAMPLE_PERIODS (SAMPLE_PERIODS),
    .RES_W          (RES_W),
    .TOTAL_PERIODS  (TOTAL_PERIODS),
    .IW             (IW)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .tick   (conv_tick),
    .phase  (phase),
    .bitpos (bitpos),
    .last   (end_of_conv)
  );

  sar_approx_reg #(
    .RES_W (RES_W),
    .IW    (IW)
  ) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .active     (phase == PH_TRIAL),
    .step       (conv_tick),
    .bitpos     (bitpos),
    .cmp_hi     (cmp_hi),
    .trial_mask (trial_mask),
    .code       (dac_code)
  );

  assign sample_en = (phase == PH_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      done <= end_of_conv;
      if (end_of_conv) begin
        result <= dac_code;
        irq    <= 1'b1;
      end else if (accept) begin
        irq    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int RES_W         = 8,
  parameter int CH_W          = 3,
  parameter int TOTAL_PERIODS = 31,
  parameter int DIV_FAST      = 4,
  parameter int DIV_SLOW      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             sample_en,
  input logic             done,
  input logic             irq,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] trial_mask,
  input logic [CH_W-1:0]  chan_mux
);
  localparam int LEN_FAST = conv_cycles(TOTAL_PERIODS, DIV_FAST);
  localparam int LEN_SLOW = conv_cycles(TOTAL_PERIODS, DIV_SLOW);

  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_len <= 0;
    else if (!busy)
      busy_len <= 0;
    else
      busy_len <= busy_len + 1;
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);

  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq);

  a_r4_sample_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  a_r4_dac_zero_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));

  a_r5_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial_mask));

  a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_mux));

  a_r3_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == LEN_FAST || busy_len == LEN_SLOW));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .RES_W         (RES_W),
  .CH_W          (CH_W),
  .TOTAL_PERIODS (TOTAL_PERIODS),
  .DIV_FAST      (DIV_FAST),
  .DIV_SLOW      (DIV_SLOW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .busy       (busy),
  .sample_en  (sample_en),
  .done       (done),
  .irq        (irq),
  .dac_code   (dac_code),
  .result     (result),
  .trial_mask (trial_mask),
  .chan_mux   (chan_mux)
);

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan_in = '0;
  logic       clk_sel = 1'b0;
  logic       cmp_hi;
  logic [2:0] chan_mux;
  logic       sample_en;
  logic [7:0] dac_code;
  logic       busy;
  logic [7:0] result;
  logic       done;
  logic       irq;

  logic [7:0] ain [8];

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] res;
    int         div;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  // Ideal comparator on the selected channel.
  assign cmp_hi = (ain[chan_mux] >= dac_code);

  sar_conv_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chan_in   (chan_in),
    .clk_sel   (clk_sel),
    .cmp_hi    (cmp_hi),
    .chan_mux  (chan_mux),
    .sample_en (sample_en),
    .dac_code  (dac_code),
    .busy      (busy),
    .result    (result),
    .done      (done),
    .irq       (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: counts busy and acquire cycles, probes trial codes, scores results.
  int cyc = 0;
  int samp = 0;
  always @(negedge clk) begin
    if (rst_n && busy && sb.size() != 0) begin
      cyc++;
      if (sample_en) samp++;
      if (cyc == 10 * sb[0].div + 1)
        chk(dac_code == 8'h80, "R5 first trial is MSB", dac_code, 8'h80);
      if (cyc == 11 * sb[0].div + 1)
        chk(dac_code == ((sb[0].res & 8'h80) | 8'h40), "R5 second trial",
            dac_code, (sb[0].res & 8'h80) | 8'h40);
    end
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        chk(result == sb[0].res, "R6 result", result, sb[0].res);
        chk(cyc == 31 * sb[0].div, "R3 busy length", cyc, 31 * sb[0].div);
        chk(samp == 10 * sb[0].div, "R4 acquire length", samp, 10 * sb[0].div);
        chk(irq == 1'b1, "R8 irq with done", irq, 1);
        void'(sb.pop_front());
      end
      cyc = 0;
      samp = 0;
    end
  end

  // Driver: mode 1 = stray start mid-run (R9), mode 2 = input change mid-run (R10).
  task automatic run_conv(input int ch, input logic sel, input int mode);
    exp_t e;
    while (busy) @(negedge clk);
    @(negedge clk);
    chan_in = 3'(ch);
    clk_sel = sel;
    start   = 1'b1;
    e.res = ain[ch];
    e.div = sel ? 8 : 4;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    chk(chan_mux == 3'(ch), "R2 channel captured", chan_mux, ch);
    chk(irq == 1'b0, "R8 irq cleared by start", irq, 0);
    if (mode == 1) begin
      repeat (40) @(negedge clk);
      chan_in = 3'((ch + 3) % 8);
      clk_sel = !sel;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(chan_mux == 3'(ch), "R9 start while busy ignored", chan_mux, ch);
    end else if (mode == 2) begin
      repeat (20) @(negedge clk);
      chan_in = 3'((ch + 5) % 8);
      clk_sel = !sel;
      repeat (3) @(negedge clk);
      chk(chan_mux == 3'(ch), "R10 channel held", chan_mux, ch);
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(irq == 1'b1, "R8 irq held", irq, 1);
  endtask

  initial begin
    ain[0] = 8'h00; ain[1] = 8'hFF; ain[2] = 8'h80; ain[3] = 8'h7F;
    ain[4] = 8'h5A; ain[5] = 8'hA5; ain[6] = 8'h01; ain[7] = 8'h3C;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && irq == 1'b0, "R1 flags in reset",
        {busy, done, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 8'h00 && dac_code == 8'h00, "R1 result and dac", result, 0);
    chk(sample_en == 1'b0 && chan_mux == 3'd0, "R1 acquire and channel",
        {sample_en, chan_mux}, 0);

    run_conv(0, 1'b0, 0);
    run_conv(1, 1'b1, 0);
    run_conv(2, 1'b0, 0);
    run_conv(3, 1'b1, 0);
    run_conv(4, 1'b0, 1);
    run_conv(5, 1'b1, 1);
    run_conv(6, 1'b0, 2);
    run_conv(7, 1'b1, 2);

    repeat (10) @(negedge clk);
    chk(result == ain[7], "R7 result held when idle", result, ain[7]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule